// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one output channel of a general-purpose timer. It watches an external counter value and its counting direction. It compares the counter against a programmable compare value and produces an active-high internal reference level. A second output, the pin level, is that reference passed through a selectable inversion. A 3-bit mode field selects how the reference behaves:

- it holds its value;
- it is set, cleared or toggled on a compare match;
- it is forced to a fixed level;
- it follows one of two direction-aware PWM laws.

The compare value can be written directly into the active register. Alternatively it can go into a buffer that is copied to the active register on each update-event pulse. An asynchronous trigger input is synchronised and edge-detected. When the fast option is set in a PWM mode, a trigger edge takes the role of a compare match. The counter, its reload logic and the register bus are outside the block; they appear as plain ports.

The comparison is pipelined. A change on the counter reaches the reference after three clock edges: one to register the counter, one to register the comparison, one to update the reference. The trigger fast path also takes three edges: two synchroniser stages, then the reference update. When a counter that restarts on the synchronised trigger is routed through the compare path, the trigger-to-output time is five edges.

Top module: `tcc_oc_channel`

## Requirements
- R1: After reset the reference and pin outputs are 0, the compare read-back is 0, the mode is 000 (hold), and buffering, fast trigger and inversion are off.
- R2: In mode 000 the reference keeps its value whatever the counter does.
- R3: In mode 001 a rising compare equality sets the reference to 1. In mode 010 it clears the reference to 0. The reference changes on the third clock edge after the counter reaches the compare value, and not earlier.
- R4: In mode 011 each rising compare equality inverts the reference once, however long the equality lasts.
- R5: Mode 100 drives the reference to 0 and mode 101 drives it to 1.
- R6: Mode 110 (PWM 1) behaves as follows:
  - counting up (direction input 0), the reference is 1 while counter < compare and 0 otherwise;
  - counting down (direction input 1), it is 0 while counter > compare and 1 otherwise.
- R7: Mode 111 (PWM 2) gives the inverse of R6 in both directions.
- R8: In PWM modes the reference is rewritten only when the PWM level changes, or on entry from mode 000.
- R9: With buffering off, a compare write reaches the active compare value, and the read-back, on the next clock edge.
- R10: With buffering on, a compare write goes to the buffer and the read-back shows the buffer. The active value changes only when an update pulse copies the buffer across.
- R11: With the fast bit set in a PWM mode, a trigger rising edge drives the reference to the level a match would give: PWM 1 gives 0 counting up and 1 counting down; PWM 2 gives the opposite. This happens on the third clock edge after the trigger rises.
- R12: With the fast bit clear, a trigger edge has no direct effect on the reference. A counter that restarts on the synchronised trigger moves the reference on the fifth edge after the trigger.
- R13: The pin output equals the reference when the inversion bit is 0, and its complement when the bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current counter value |
| cnt_down_i | input | 1 | Counting direction, 1 = down |
| upd_i | input | 1 | Update-event pulse |
| trig_i | input | 1 | Asynchronous trigger level |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write data |
| cmp_rdata_o | output | CNT_W | Compare read-back (buffer if buffering is on, else active) |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_mode_i | input | 3 | Mode field |
| ctl_buf_en_i | input | 1 | Compare buffering enable |
| ctl_fast_en_i | input | 1 | Trigger fast path enable |
| ctl_pol_i | input | 1 | Pin inversion |
| oc_ref_o | output | 1 | Active-high reference |
| oc_pin_o | output | 1 | Pin level after polarity |

## Verification
The bench builds the channel with CNT_W = 8 and SYNC_STAGES = 2. The narrow counter keeps a full PWM period short, so duty can be counted over whole periods in both directions with a compare value near the bottom of the range. Two synchroniser stages make the trigger latencies exactly three edges with the fast bit set and five with it clear. The bench samples the cycles just before and at each of these edges, so an extra or missing register shows up.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [2:0] {
    M_FROZEN = 3'b000,
    M_SET    = 3'b001,
    M_CLR    = 3'b010,
    M_TOG    = 3'b011,
    M_LO     = 3'b100,
    M_HI     = 3'b101,
    M_PWM1   = 3'b110,
    M_PWM2   = 3'b111
  } oc_mode_e;

  typedef struct packed {
    oc_mode_e mode;
    logic     buf_en;
    logic     fast_en;
    logic     pol;
  } oc_ctl_t;

  function automatic logic is_pwm(oc_mode_e m);
    return m[2] & m[1];
  endfunction

endpackage

// File: rtl/tcc_ccr_bank.sv
module tcc_ccr_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         buf_en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         upd_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] act_q, buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      buf_q <= '0;
    end else begin
      if (upd_i && buf_en_i)       act_q <= buf_q;
      else if (wr_i && !buf_en_i)  act_q <= wdata_i;
      if (wr_i && buf_en_i)        buf_q <= wdata_i;
    end
  end

  assign act_o = act_q;
  assign rd_o  = buf_en_i ? buf_q : act_q;
endmodule

// File: rtl/tcc_trig_edge.sv
module tcc_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= trig_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], trig_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tcc_cmp_pipe.sv
module tcc_cmp_pipe
  import tcc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic [W-1:0] ccr_i,
  input  oc_mode_e     mode_i,
  output logic         eq_o,
  output logic         lvl_o,
  output logic         entry_o,
  output logic         down_o
);
  logic [W-1:0] cnt_q;
  logic         down_q, down2_q, eq_q, lvl_q, entry_q;
  oc_mode_e     mode_prev_q;
  logic         pwm1_c, pwm_c;

  // stage 1 holds the counter sample; stage 2 holds comparison results
  assign pwm1_c = down_q ? (cnt_q <= ccr_i) : (cnt_q < ccr_i);
  assign pwm_c  = (mode_i == M_PWM2) ? ~pwm1_c : pwm1_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      down_q      <= 1'b0;
      down2_q     <= 1'b0;
      eq_q        <= 1'b0;
      lvl_q       <= 1'b0;
      entry_q     <= 1'b0;
      mode_prev_q <= M_FROZEN;
    end else begin
      cnt_q       <= cnt_i;
      down_q      <= down_i;
      down2_q     <= down_q;
      eq_q        <= (cnt_q == ccr_i);
      lvl_q       <= pwm_c;
      entry_q     <= is_pwm(mode_i) && (mode_prev_q == M_FROZEN);
      mode_prev_q <= mode_i;
    end
  end

  assign eq_o    = eq_q;
  assign lvl_o   = lvl_q;
  assign entry_o = entry_q;
  assign down_o  = down2_q;
endmodule

// File: rtl/tcc_ref_stage.sv
module tcc_ref_stage
  import tcc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  oc_mode_e mode_i,
  input  logic     fast_en_i,
  input  logic     trig_edge_i,
  input  logic     eq_i,
  input  logic     lvl_i,
  input  logic     entry_i,
  input  logic     down_i,
  output logic     ref_o
);
  logic ref_q, eq_d, lvl_d, nxt;
  logic match_p, fast_lvl;

  assign match_p  = eq_i & ~eq_d;
  // level a compare match would produce in the current direction
  assign fast_lvl = (mode_i == M_PWM2) ? ~down_i : down_i;

  always_comb begin
    nxt = ref_q;
    unique case (mode_i)
      M_FROZEN: nxt = ref_q;
      M_SET:    if (match_p) nxt = 1'b1;
      M_CLR:    if (match_p) nxt = 1'b0;
      M_TOG:    if (match_p) nxt = ~ref_q;
      M_LO:     nxt = 1'b0;
      M_HI:     nxt = 1'b1;
      M_PWM1, M_PWM2: begin
        if (fast_en_i && trig_edge_i)       nxt = fast_lvl;
        else if (entry_i || lvl_i != lvl_d) nxt = lvl_i;
      end
      default:  nxt = ref_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      eq_d  <= 1'b0;
      lvl_d <= 1'b0;
    end else begin
      ref_q <= nxt;
      eq_d  <= eq_i;
      lvl_d <= lvl_i;
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/tcc_oc_channel.sv
module tcc_oc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             trig_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cmp_rdata_o,
  input  logic             ctl_wr_i,
  input  logic [2:0]       ctl_mode_i,
  input  logic             ctl_buf_en_i,
  input  logic             ctl_fast_en_i,
  input  logic             ctl_pol_i,
  output logic             oc_ref_o,
  output logic             oc_pin_o
);
  oc_ctl_t          ctl_q;
  oc_mode_e         mode_w;
  logic             buf_en_w, fast_en_w, pol_w;
  logic [CNT_W-1:0] ccr_act_w;
  logic             trig_edge_w, eq_w, lvl_w, entry_w, dir2_w, ref_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '{mode: M_FROZEN, buf_en: 1'b0, fast_en: 1'b0, pol: 1'b0};
    end else if (ctl_wr_i) begin
      ctl_q <= '{mode: oc_mode_e'(ctl_mode_i), buf_en: ctl_buf_en_i,
                 fast_en: ctl_fast_en_i, pol: ctl_pol_i};
    end
  end

  assign mode_w    = ctl_q.mode;
  assign buf_en_w  = ctl_q.buf_en;
  assign fast_en_w = ctl_q.fast_en;
  assign pol_w     = ctl_q.pol;

  tcc_ccr_bank #(.W(CNT_W)) u_ccr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .buf_en_i (buf_en_w),
    .wr_i     (cmp_wr_i),
    .wdata_i  (cmp_wdata_i),
    .upd_i    (upd_i),
    .act_o    (ccr_act_w),
    .rd_o     (cmp_rdata_o)
  );

  tcc_trig_edge #(.STAGES(SYNC_STAGES)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .edge_o (trig_edge_w)
  );

  tcc_cmp_pipe #(.W(CNT_W)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .down_i  (cnt_down_i),
    .ccr_i   (ccr_act_w),
    .mode_i  (mode_w),
    .eq_o    (eq_w),
    .lvl_o   (lvl_w),
    .entry_o (entry_w),
    .down_o  (dir2_w)
  );

  tcc_ref_stage u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_w),
    .fast_en_i   (fast_en_w),
    .trig_edge_i (trig_edge_w),
    .eq_i        (eq_w),
    .lvl_i       (lvl_w),
    .entry_i     (entry_w),
    .down_i      (dir2_w),
    .ref_o       (ref_w)
  );

  assign oc_ref_o = ref_w;
  assign oc_pin_o = ref_w ^ pol_w;
endmodule

// File: rtl/tcc_oc_checker.sv
module tcc_oc_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   mode_i,
  input logic         buf_en_i,
  input logic         fast_en_i,
  input logic         pol_i,
  input logic         trig_edge_i,
  input logic         dir_i,
  input logic [W-1:0] ccr_act_i,
  input logic         cmp_wr_i,
  input logic [W-1:0] cmp_wdata_i,
  input logic         upd_i,
  input logic         ref_i,
  input logic         pin_i
);
  p_frozen_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b000) |=> $stable(ref_i));

  p_force_lvl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:1] == 2'b10) |=> (ref_i == $past(mode_i[0])));

  p_direct_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr_i && !buf_en_i) |=> (ccr_act_i == $past(cmp_wdata_i)));

  p_shadow_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_i && !upd_i) |=> $stable(ccr_act_i));

  p_fast_lvl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:1] == 2'b11 && fast_en_i && trig_edge_i)
      |=> (ref_i == ($past(mode_i[0]) ^ $past(dir_i))));

  p_pol_flip_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i != $past(pol_i)) && $stable(ref_i) |-> (pin_i != $past(pin_i)));
endmodule

bind tcc_oc_channel tcc_oc_checker #(.W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_w),
  .buf_en_i    (buf_en_w),
  .fast_en_i   (fast_en_w),
  .pol_i       (pol_w),
  .trig_edge_i (trig_edge_w),
  .dir_i       (dir2_w),
  .ccr_act_i   (ccr_act_w),
  .cmp_wr_i    (cmp_wr_i),
  .cmp_wdata_i (cmp_wdata_i),
  .upd_i       (upd_i),
  .ref_i       (oc_ref_o),
  .pin_i       (oc_pin_o)
);

// File: tb/sim_tcc_oc_channel.sv
module sim_tcc_oc_channel;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = 8;
  localparam logic [2:0] FRZ = 3'b000, SETM = 3'b001, CLRM = 3'b010, TOGM = 3'b011,
                         LOM = 3'b100, HIM = 3'b101, PW1 = 3'b110, PW2 = 3'b111;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             cnt_down_i = 1'b0;
  logic             upd_i = 1'b0;
  logic             trig_i = 1'b0;
  logic             cmp_wr_i = 1'b0;
  logic [CNT_W-1:0] cmp_wdata_i = '0;
  logic [CNT_W-1:0] cmp_rdata_o;
  logic             ctl_wr_i = 1'b0;
  logic [2:0]       ctl_mode_i = '0;
  logic             ctl_buf_en_i = 1'b0;
  logic             ctl_fast_en_i = 1'b0;
  logic             ctl_pol_i = 1'b0;
  logic             oc_ref_o, oc_pin_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  tcc_oc_channel #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
    .clk_i, .rst_ni, .cnt_i, .cnt_down_i, .upd_i, .trig_i,
    .cmp_wr_i, .cmp_wdata_i, .cmp_rdata_o,
    .ctl_wr_i, .ctl_mode_i, .ctl_buf_en_i, .ctl_fast_en_i, .ctl_pol_i,
    .oc_ref_o, .oc_pin_o
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [2:0] m, input logic b, input logic f, input logic p);
    ctl_mode_i = m; ctl_buf_en_i = b; ctl_fast_en_i = f; ctl_pol_i = p;
    ctl_wr_i = 1'b1;
    step(1);
    ctl_wr_i = 1'b0;
  endtask

  task automatic wr_cmp(input int v);
    cmp_wdata_i = CNT_W'(v);
    cmp_wr_i = 1'b1;
    step(1);
    cmp_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ref after reset", int'(oc_ref_o), 0);
    chk("R1 pin after reset", int'(oc_pin_o), 0);
    chk("R1 compare read after reset", int'(cmp_rdata_o), 0);
  endtask

  task automatic t_match;
    wr_cmp(50);
    cnt_i = 0;
    wr_ctl(LOM, 0, 0, 0); step(4);
    wr_ctl(SETM, 0, 0, 0); step(4);
    cnt_i = 50;
    step(2);
    chk("R3 set not before third edge", int'(oc_ref_o), 0);
    step(1);
    chk("R3 set on match at third edge", int'(oc_ref_o), 1);
    wr_ctl(CLRM, 0, 0, 0); step(4);
    chk("R3 clear needs a new match", int'(oc_ref_o), 1);
    cnt_i = 0; step(4);
    cnt_i = 50; step(3);
    chk("R3 clear on match", int'(oc_ref_o), 0);
  endtask

  task automatic t_toggle;
    cnt_i = 0;
    wr_ctl(TOGM, 0, 0, 0); step(4);
    cnt_i = 50; step(6);
    chk("R4 single toggle on held match", int'(oc_ref_o), 1);
    cnt_i = 0; step(4);
    cnt_i = 50; step(4);
    chk("R4 second toggle", int'(oc_ref_o), 0);
  endtask

  task automatic t_frozen_force_pol;
    wr_ctl(HIM, 0, 0, 0); step(3);
    chk("R5 forced high", int'(oc_ref_o), 1);
    wr_ctl(FRZ, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      cnt_i = (k % 2 == 0) ? 8'd50 : 8'd0;
      step(3);
    end
    chk("R2 frozen holds high", int'(oc_ref_o), 1);
    wr_ctl(LOM, 0, 0, 0); step(3);
    chk("R5 forced low", int'(oc_ref_o), 0);
    chk("R13 pin equals ref", int'(oc_pin_o), 0);
    wr_ctl(LOM, 0, 0, 1); step(1);
    chk("R13 pin inverted low ref", int'(oc_pin_o), 1);
    wr_ctl(HIM, 0, 0, 1); step(3);
    chk("R13 pin inverted high ref", int'(oc_pin_o), 0);
    wr_ctl(FRZ, 0, 0, 0); step(2);
  endtask

  task automatic t_entry;
    // ref is 1 from forced high; frozen level below compare stays unchanged
    wr_ctl(HIM, 0, 0, 0); step(3);
    wr_ctl(FRZ, 0, 0, 0);
    cnt_i = 200; step(5);
    wr_ctl(PW1, 0, 0, 0); step(3);
    chk("R8 frozen to PWM1 entry refreshes level", int'(oc_ref_o), 0);
    wr_ctl(FRZ, 0, 0, 0); step(3);
    wr_ctl(PW2, 0, 0, 0); step(3);
    chk("R8 frozen to PWM2 entry refreshes level", int'(oc_ref_o), 1);
  endtask

  task automatic t_pwm_levels;
    for (int md = 0; md < 2; md++) begin
      for (int dn = 0; dn < 2; dn++) begin
        wr_ctl(FRZ, 0, 0, 0); step(2);
        cnt_down_i = dn[0];
        wr_ctl(md == 0 ? PW1 : PW2, 0, 0, 0); step(3);
        for (int c = 49; c <= 51; c++) begin
          int e;
          cnt_i = CNT_W'(c);
          step(4);
          e = dn ? int'(c <= 50) : int'(c < 50);
          if (md == 1) e = 1 - e;
          if (md == 0) chk($sformatf("R6 PWM1 dn=%0d cnt=%0d", dn, c), int'(oc_ref_o), e);
          else         chk($sformatf("R7 PWM2 dn=%0d cnt=%0d", dn, c), int'(oc_ref_o), e);
        end
      end
    end
    cnt_down_i = 1'b0;
  endtask

  task automatic t_duty(input logic [2:0] m, input logic dn, input int exp_hi, input string tag);
    int hi = 0;
    wr_cmp(7);
    wr_ctl(FRZ, 0, 0, 0); step(2);
    cnt_down_i = dn;
    wr_ctl(m, 0, 0, 0);
    for (int k = 0; k < 60; k++) begin
      cnt_i = CNT_W'(dn ? 19 - (k % 20) : (k % 20));
      step(1);
      if (k >= 40 && oc_ref_o) hi++;
    end
    chk(tag, hi, exp_hi);
    cnt_down_i = 1'b0;
  endtask

  task automatic t_buffer;
    wr_ctl(FRZ, 0, 0, 0); step(2);
    wr_cmp(100);
    cnt_i = 150;
    wr_ctl(PW1, 0, 0, 0); step(4);
    chk("R6 baseline low", int'(oc_ref_o), 0);
    wr_cmp(200);
    chk("R9 direct write read-back", int'(cmp_rdata_o), 200);
    step(3);
    chk("R9 direct write reaches compare", int'(oc_ref_o), 1);
    wr_ctl(PW1, 1, 0, 0);
    wr_cmp(100);
    chk("R10 read-back shows buffer", int'(cmp_rdata_o), 100);
    step(5);
    chk("R10 buffered write not active", int'(oc_ref_o), 1);
    upd_i = 1'b1; step(1); upd_i = 1'b0;
    step(3);
    chk("R10 update copies buffer", int'(oc_ref_o), 0);
    wr_ctl(PW1, 0, 0, 0);
    chk("R10 active read-back after disable", int'(cmp_rdata_o), 100);
  endtask

  task automatic t_fast;
    wr_ctl(FRZ, 0, 0, 0); step(2);
    wr_cmp(100);
    cnt_i = 10;
    wr_ctl(PW1, 0, 1, 0); step(4);
    chk("R6 pre-trigger high", int'(oc_ref_o), 1);
    trig_i = 1'b1;
    step(2);
    chk("R11 no change before third edge", int'(oc_ref_o), 1);
    step(1);
    chk("R11 fast trigger at third edge", int'(oc_ref_o), 0);
    step(4);
    chk("R8 held while PWM level unchanged", int'(oc_ref_o), 0);
    trig_i = 1'b0;
    cnt_i = 200; step(4);
    cnt_i = 10; step(4);
    chk("R8 level change rewrites ref", int'(oc_ref_o), 1);
  endtask

  task automatic t_slow;
    wr_ctl(PW1, 0, 0, 0); step(4);
    chk("R12 pre-trigger high", int'(oc_ref_o), 1);
    trig_i = 1'b1;
    step(1);
    chk("R12 edge 1", int'(oc_ref_o), 1);
    step(1);
    chk("R12 edge 2", int'(oc_ref_o), 1);
    cnt_i = 200; // counter restart seen after synchroniser
    step(1);
    chk("R12 trigger has no direct effect", int'(oc_ref_o), 1);
    step(1);
    chk("R12 edge 4", int'(oc_ref_o), 1);
    step(1);
    chk("R12 output moves at fifth edge", int'(oc_ref_o), 0);
    trig_i = 1'b0;
    step(3);
  endtask

  initial begin
    #(100_000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_match();
    t_toggle();
    t_frozen_force_pol();
    t_entry();
    t_pwm_levels();
    t_duty(PW1, 1'b0, 7,  "R6 PWM1 duty counting up");
    t_duty(PW1, 1'b1, 8,  "R6 PWM1 duty counting down");
    t_duty(PW2, 1'b0, 13, "R7 PWM2 duty counting up");
    t_duty(PW2, 1'b1, 12, "R7 PWM2 duty counting down");
    t_buffer();
    t_fast();
    t_slow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule